// File: doc/BRIEF.md
# Two-Pass 8x8 Inverse Transform Pixel Reconstructor

This block rebuilds an 8x8 tile of 8-bit pixels from an 8x8 tile of signed 16-bit frequency coefficients. Coefficient rows stream in one per accepted beat. Once all eight are held, a shared 8-point fixed-point butterfly makes a vertical pass over the eight columns, one column per cycle, into a transpose store. It then makes a horizontal pass, one row per cycle, and each pass-two row leaves as one output beat.

A mode bit is taken with the first coefficient row. In mid-grey mode the rebuilt samples are offset by half of full scale. In residual mode each sample is added to the matching pixel of a prediction row, which comes in on its own handshake. Every result is saturated to the 8-bit range. A pass-two line whose entries 1..7 are all zero skips the butterfly and uses a single scaled term. A one-cycle pulse marks the acceptance of the last pixel row. The next tile is taken only after that pulse.

Top module: `idct2d_recon`

## Requirements
- R1: During reset and after it, coef_ready is high while pix_valid, pred_ready and blk_done are low.
- R2: A tile is eight coefficient rows accepted on coef_valid && coef_ready, in row order 0..7, with column j at bits [16j+15:16j]. From the cycle after the eighth row until the tile's last pixel row is taken, coef_ready stays low, and it is never high while pix_valid is high.
- R3: The first pass runs down each column c0..c7 with no rounding, using these constants: 64277, 60547, 54491, 46341, 36410, 25080 and 12785. Every product is arithmetically shifted right by 16 on its own. Odd terms are A=c1·64277+c7·12785, B=c1·12785−c7·64277, C=c3·54491+c5·36410, D=c5·54491−c3·36410, Ad=(A−C)·46341, Bd=(B−D)·46341, Cd=A+C and Dd=B+D. Even terms are E=(c0+c4)·46341, F=(c0−c4)·46341, G=c2·60547+c6·25080 and H=c2·25080−c6·60547. The outputs 0..7 are Gd+Cd, Add+Hd, Add−Hd, Ed+Dd, Ed−Dd, Fd+Bdd, Fd−Bdd and Gd−Cd, where Gd=E+G, Ed=E−G, Add=F+Ad, Fd=F−Ad, Hd=Bd+H and Bdd=Bd−H.
- R4: The second pass applies the same butterfly along each row of first-pass results. It adds 8 to E and F, and it shifts each of the eight outputs arithmetically right by 4.
- R5: In mid-grey mode (coef_put=1), the second pass also adds 2048 to E and F, and the shifted value is the pixel before saturation.
- R6: In residual mode (coef_put=0), pixel k of output row i is the shifted sample plus pixel k of prediction row i, then saturated.
- R7: Every output pixel is saturated to 0..255.
- R8: A second-pass line whose entries 1..7 are zero gives every pixel of its row as (x0·46341 + 524288) >> 20, plus 128 in mid-grey mode or plus the prediction pixel in residual mode, then saturated.
- R9: The mode is taken from coef_put on the first coefficient row of a tile, and coef_put on rows 1..7 has no effect.
- R10: pred_ready is never high in mid-grey mode. In residual mode one prediction row is accepted per output row, in order, and output row i is not offered before prediction row i is accepted.
- R11: While pix_valid is high and pix_ready low, pix_valid stays high and pix_row is held unchanged on the next cycle.
- R12: blk_done is high for exactly one cycle: the cycle after the eighth pixel row of a tile is accepted.
- R13: Pixel rows leave in order 0..7, with pixel k at bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_valid | input | 1 | Coefficient row offered |
| coef_ready | output | 1 | Coefficient row can be taken |
| coef_put | input | 1 | Mode, taken with row 0: 1 mid-grey, 0 residual |
| coef_row | input | 128 | Eight signed 16-bit coefficients of one row |
| pred_valid | input | 1 | Prediction row offered |
| pred_ready | output | 1 | Prediction row taken this cycle |
| pred_row | input | 64 | Eight unsigned prediction pixels |
| pix_valid | output | 1 | Pixel row offered |
| pix_ready | input | 1 | Pixel row taken by the receiver |
| pix_row | output | 64 | Eight reconstructed pixels |
| blk_done | output | 1 | One-cycle pulse after the tile's last row is taken |

## Verification
The hardest state to reach is a residual-mode tile stalled from both sides at once. Output back-pressure is active while the prediction stream lags, so pred_ready, the held pixel row and the row counter must all stay put together. The stimulus holds the prediction rows back for many cycles after the transform has finished and toggles pix_ready pseudo-randomly, which checks both stall sources against the same expected rows. The single-term path is reached with tiles whose only nonzero coefficients lie in column 0. These tiles make every second-pass line qualify, and their results must equal the full butterfly's.

// File: rtl/idct2d_pkg.sv
package idct2d_pkg;
  localparam int NPT  = 8;
  localparam int CNTW = $clog2(NPT);

  // fixed-point cosine multipliers, scale 2^16
  localparam logic [16:0] KC1 = 17'd64277;
  localparam logic [16:0] KC2 = 17'd60547;
  localparam logic [16:0] KC3 = 17'd54491;
  localparam logic [16:0] KC4 = 17'd46341;
  localparam logic [16:0] KC5 = 17'd36410;
  localparam logic [16:0] KC6 = 17'd25080;
  localparam logic [16:0] KC7 = 17'd12785;

  localparam int FRAC   = 16;
  localparam int SHIFT2 = 4;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_COL   = 2'd1,
    ST_ROW   = 2'd2,
    ST_DRAIN = 2'd3
  } fsm_t;
endpackage

// File: rtl/idct2d_rst_sync.sv
module idct2d_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/idct2d_butterfly.sv
module idct2d_butterfly
  import idct2d_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic signed [AW-1:0] x    [NPT],
  input  logic signed [AW-1:0] bias,
  output logic signed [AW-1:0] y    [NPT]
);
  localparam int PWID = AW + 18;

  function automatic logic signed [AW-1:0] scl(input logic signed [AW-1:0] v,
                                               input logic [16:0] k);
    logic signed [PWID-1:0] p;
    p = $signed({{18{v[AW-1]}}, v}) * $signed({{(AW+1){1'b0}}, k});
    return p[AW+FRAC-1:FRAC];
  endfunction

  logic signed [AW-1:0] a_t, b_t, c_t, d_t, ad_t, bd_t, cd_t, dd_t;
  logic signed [AW-1:0] e_t, f_t, g_t, h_t, ed_t, gd_t, add_t, fd_t, bdd_t, hd_t;

  always_comb begin
    a_t   = scl(x[1], KC1) + scl(x[7], KC7);
    b_t   = scl(x[1], KC7) - scl(x[7], KC1);
    c_t   = scl(x[3], KC3) + scl(x[5], KC5);
    d_t   = scl(x[5], KC3) - scl(x[3], KC5);
    ad_t  = scl(a_t - c_t, KC4);
    bd_t  = scl(b_t - d_t, KC4);
    cd_t  = a_t + c_t;
    dd_t  = b_t + d_t;
    e_t   = scl(x[0] + x[4], KC4) + bias;
    f_t   = scl(x[0] - x[4], KC4) + bias;
    g_t   = scl(x[2], KC2) + scl(x[6], KC6);
    h_t   = scl(x[2], KC6) - scl(x[6], KC2);
    ed_t  = e_t - g_t;
    gd_t  = e_t + g_t;
    add_t = f_t + ad_t;
    fd_t  = f_t - ad_t;
    bdd_t = bd_t - h_t;
    hd_t  = bd_t + h_t;
    y[0]  = gd_t + cd_t;
    y[1]  = add_t + hd_t;
    y[2]  = add_t - hd_t;
    y[3]  = ed_t + dd_t;
    y[4]  = ed_t - dd_t;
    y[5]  = fd_t + bdd_t;
    y[6]  = fd_t - bdd_t;
    y[7]  = gd_t - cd_t;
  end
endmodule

// File: rtl/idct2d_recon_lane.sv
module idct2d_recon_lane
  import idct2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input  logic signed [AW-1:0] full_sum,
  input  logic signed [AW-1:0] dc_sum,
  input  logic                 use_dc,
  input  logic                 put,
  input  logic [PW-1:0]        pred,
  output logic [PW-1:0]        pix
);
  localparam logic signed [AW-1:0] MIDV = AW'(2 ** (PW - 1));
  localparam logic signed [AW-1:0] MAXV = AW'(2 ** PW - 1);

  logic signed [AW-1:0] base, addend, total;

  always_comb begin
    base = use_dc ? dc_sum : (full_sum >>> SHIFT2);
    if (put) addend = use_dc ? MIDV : '0;
    else     addend = {{(AW-PW){1'b0}}, pred};
    total = base + addend;
    if (total < 0)         pix = '0;
    else if (total > MAXV) pix = '1;
    else                   pix = total[PW-1:0];
  end
endmodule

// File: rtl/idct2d_recon.sv
module idct2d_recon
  import idct2d_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_valid,
  output logic             coef_ready,
  input  logic             coef_put,
  input  logic [NPT*CW-1:0] coef_row,
  input  logic             pred_valid,
  output logic             pred_ready,
  input  logic [NPT*PW-1:0] pred_row,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [NPT*PW-1:0] pix_row,
  output logic             blk_done
);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(NPT - 1);
  localparam logic signed [AW-1:0] RND2    = AW'(2 ** (SHIFT2 - 1));
  localparam logic signed [AW-1:0] PUT_RND = AW'(2 ** (SHIFT2 - 1) + 2 ** (PW - 1 + SHIFT2));
  localparam int DCW = AW + 20;
  localparam logic signed [DCW-1:0] DC_RND = DCW'(2 ** (FRAC + SHIFT2 - 1));

  logic rst_sync_n;

  idct2d_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsm_t            state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            mode_q, mode_d;
  logic            pvld_q, pvld_d;
  logic            done_q, done_d;
  logic [NPT*PW-1:0] prow_q;

  logic signed [CW-1:0] coef_buf [NPT][NPT];
  logic signed [AW-1:0] tbuf     [NPT][NPT];

  logic                 coef_we, t_we, slot_free, row_fire, row_dc;
  logic signed [AW-1:0] core_x [NPT];
  logic signed [AW-1:0] core_y [NPT];
  logic signed [AW-1:0] core_bias;
  logic signed [AW-1:0] dc_val;
  logic signed [DCW-1:0] dc_prod;
  logic [NPT*PW-1:0]    recon_row;

  assign slot_free  = !pvld_q || pix_ready;
  assign row_fire   = (state_q == ST_ROW) && slot_free && (mode_q || pred_valid);
  assign coef_ready = (state_q == ST_LOAD);
  assign pred_ready = (state_q == ST_ROW) && !mode_q && slot_free;
  assign coef_we    = coef_ready && coef_valid;
  assign t_we       = (state_q == ST_COL);
  assign pix_valid  = pvld_q;
  assign pix_row    = prow_q;
  assign blk_done   = done_q;

  // shared butterfly input selection: columns of coefficients, then rows of pass one
  always_comb begin
    for (int i = 0; i < NPT; i++) begin
      if (state_q == ST_COL)
        core_x[i] = {{(AW-CW){coef_buf[i][cnt_q][CW-1]}}, coef_buf[i][cnt_q]};
      else
        core_x[i] = tbuf[cnt_q][i];
    end
    if (state_q == ST_COL) core_bias = '0;
    else                   core_bias = mode_q ? PUT_RND : RND2;
  end

  idct2d_butterfly #(.AW(AW)) u_bfly (
    .x    (core_x),
    .bias (core_bias),
    .y    (core_y)
  );

  // single-term path for lines with only entry 0 nonzero
  always_comb begin
    row_dc = 1'b1;
    for (int j = 1; j < NPT; j++)
      if (tbuf[cnt_q][j] != '0) row_dc = 1'b0;
    dc_prod = $signed({{20{tbuf[cnt_q][0][AW-1]}}, tbuf[cnt_q][0]})
              * $signed({{(DCW-17){1'b0}}, KC4}) + DC_RND;
    dc_val  = dc_prod[AW+FRAC+SHIFT2-1:FRAC+SHIFT2];
  end

  for (genvar k = 0; k < NPT; k++) begin : g_lane
    idct2d_recon_lane #(.AW(AW), .PW(PW)) u_lane (
      .full_sum (core_y[k]),
      .dc_sum   (dc_val),
      .use_dc   (row_dc),
      .put      (mode_q),
      .pred     (pred_row[k*PW +: PW]),
      .pix      (recon_row[k*PW +: PW])
    );
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    pvld_d  = pvld_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_LOAD: begin
        if (coef_valid) begin
          if (cnt_q == '0) mode_d = coef_put;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_d = ST_COL;
        end
      end
      ST_COL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_ROW;
      end
      ST_ROW: begin
        if (pvld_q && pix_ready) pvld_d = 1'b0;
        if (row_fire) begin
          pvld_d = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (pvld_q && pix_ready) begin
          pvld_d  = 1'b0;
          done_d  = 1'b1;
          state_d = ST_LOAD;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      pvld_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      pvld_q  <= pvld_d;
      done_q  <= done_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (row_fire) prow_q <= recon_row;
  end

  always_ff @(posedge clk) begin
    if (coef_we)
      for (int j = 0; j < NPT; j++)
        coef_buf[cnt_q][j] <= $signed(coef_row[j*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (t_we)
      for (int i = 0; i < NPT; i++)
        tbuf[i][cnt_q] <= core_y[i];
  end
endmodule

// File: rtl/idct2d_checker.sv
module idct2d_checker #(
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            coef_ready,
  input logic            pred_ready,
  input logic            pix_valid,
  input logic            pix_ready,
  input logic [8*PW-1:0] pix_row,
  input logic            blk_done,
  input logic            mode_q
);
  logic [3:0] rows_seen;
  logic       hs;

  assign hs = pix_valid && pix_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rows_seen <= '0;
    else if (blk_done) rows_seen <= '0;
    else if (hs)       rows_seen <= rows_seen + 1'b1;
  end

  assert_intake_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(coef_ready && pix_valid));

  assert_pred_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pred_ready |-> !mode_q);

  assert_hold_row_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_row)));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (rows_seen == 4'd8) && $past(hs));
endmodule

bind idct2d_recon idct2d_checker #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .coef_ready (coef_ready),
  .pred_ready (pred_ready),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_row    (pix_row),
  .blk_done   (blk_done),
  .mode_q     (mode_q)
);

// File: tb/sim_idct2d_recon.sv
module sim_idct2d_recon;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, coef_valid, coef_ready, coef_put;
  logic [127:0] coef_row;
  logic         pred_valid, pred_ready;
  logic [63:0]  pred_row;
  logic         pix_valid, pix_ready;
  logic [63:0]  pix_row;
  logic         blk_done;

  idct2d_recon u0 (
    .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_ready(coef_ready),
    .coef_put(coef_put), .coef_row(coef_row), .pred_valid(pred_valid),
    .pred_ready(pred_ready), .pred_row(pred_row), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_row(pix_row), .blk_done(blk_done)
  );

  // stimulus table: [31] put, [30] back-pressure, [29:27] pattern, [26:16] amplitude, [15:0] seed
  // pattern 0 dense, 1 corner only, 2 one AC term, 3 first row, 4 first column
  localparam logic [31:0] VEC [10] = '{
    {1'b1, 1'b0, 3'd0, 11'd300,  16'h1a2b},
    {1'b0, 1'b1, 3'd0, 11'd300,  16'h7c11},
    {1'b1, 1'b1, 3'd0, 11'd2047, 16'h0f0f},
    {1'b0, 1'b0, 3'd0, 11'd2047, 16'h5555},
    {1'b1, 1'b0, 3'd1, 11'd1000, 16'h2468},
    {1'b0, 1'b0, 3'd2, 11'd500,  16'h3141},
    {1'b1, 1'b1, 3'd4, 11'd800,  16'h9abc},
    {1'b0, 1'b1, 3'd4, 11'd1500, 16'h4321},
    {1'b1, 1'b0, 3'd3, 11'd700,  16'h6006},
    {1'b0, 1'b1, 3'd3, 11'd900,  16'h0bad}
  };

  int checks = 0;
  int fails  = 0;
  logic [31:0] rs = 32'h1234_5678;
  longint mc [8][8];
  int     mp [8][8];
  int     mx [8][8];
  longint tq [8][8];
  longint vin [8];
  longint vout [8];
  logic [63:0] rxrow [8];
  bit put_cur, bp_cur, predbad;

  function automatic logic [31:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic longint sm(longint v, longint k);
    return (v * k) >>> 16;
  endfunction

  function automatic void do1d(longint bias);
    longint a, b, c, d, ad, bd, cd, dd, e, f, g, h;
    a  = sm(vin[1], 64277) + sm(vin[7], 12785);
    b  = sm(vin[1], 12785) - sm(vin[7], 64277);
    c  = sm(vin[3], 54491) + sm(vin[5], 36410);
    d  = sm(vin[5], 54491) - sm(vin[3], 36410);
    ad = sm(a - c, 46341);
    bd = sm(b - d, 46341);
    cd = a + c;
    dd = b + d;
    e  = sm(vin[0] + vin[4], 46341) + bias;
    f  = sm(vin[0] - vin[4], 46341) + bias;
    g  = sm(vin[2], 60547) + sm(vin[6], 25080);
    h  = sm(vin[2], 25080) - sm(vin[6], 60547);
    vout[0] = (e + g) + cd;
    vout[7] = (e + g) - cd;
    vout[1] = (f + ad) + (bd + h);
    vout[2] = (f + ad) - (bd + h);
    vout[3] = (e - g) + dd;
    vout[4] = (e - g) - dd;
    vout[5] = (f - ad) + (bd - h);
    vout[6] = (f - ad) - (bd - h);
  endfunction

  function automatic int sat8(longint v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return int'(v);
  endfunction

  function automatic void model(bit put);
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 8; i++) vin[i] = mc[i][j];
      do1d(0);
      for (int i = 0; i < 8; i++) tq[i][j] = vout[i];
    end
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) vin[j] = tq[i][j];
      do1d(put ? 2056 : 8);
      for (int j = 0; j < 8; j++)
        mx[i][j] = sat8((vout[j] >>> 4) + (put ? 0 : mp[i][j]));
    end
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_block(bit put);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      coef_valid = 1'b1;
      coef_put   = (r == 0) ? put : !put;   // R9: later rows carry the opposite mode
      for (int j = 0; j < 8; j++) coef_row[j*16 +: 16] = 16'(mc[r][j]);
      #1;
      while (!coef_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    coef_valid = 1'b0;
    #1;
    check(coef_ready == 1'b0, "R2 ready after eighth row", coef_ready, 0);
  endtask

  task automatic feed_pred();
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      pred_valid = 1'b1;
      for (int j = 0; j < 8; j++) pred_row[j*8 +: 8] = 8'(mp[r][j]);
      #1;
      while (!pred_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    pred_valid = 1'b0;
  endtask

  task automatic collect();
    int r = 0;
    bit hv = 0;
    logic [63:0] held = '0;
    while (r < 8) begin
      @(negedge clk);
      pix_ready = bp_cur ? nxt()[3] : 1'b1;
      #1;
      if (put_cur && pred_ready) predbad = 1;
      if (hv) check(pix_valid && pix_row == held, "R11 held row", pix_row, held);
      hv = 0;
      if (pix_valid && pix_ready) begin
        rxrow[r] = pix_row;
        r++;
      end else if (pix_valid) begin
        hv   = 1;
        held = pix_row;
      end
    end
    @(posedge clk);
    #1;
    check(blk_done == 1'b1, "R12 pulse after last row", blk_done, 1);
    check(coef_ready == 1'b1, "R2 ready again", coef_ready, 1);
    @(posedge clk);
    #1;
    check(blk_done == 1'b0, "R12 pulse width", blk_done, 0);
    @(negedge clk);
    pix_ready = 1'b0;
  endtask

  task automatic run_block(bit put, bit bp, int pdelay, string tag);
    logic [63:0] er;
    put_cur = put;
    bp_cur  = bp;
    predbad = 0;
    model(put);
    fork
      send_block(put);
      collect();
      begin
        if (!put) begin
          if (pdelay > 0) begin
            repeat (pdelay) @(negedge clk);
            #1;
            check(pix_valid == 1'b0, "R10 no row before prediction", pix_valid, 0);
          end
          feed_pred();
        end
      end
    join
    if (put) check(!predbad, "R10 pred_ready in mid-grey mode", predbad, 0);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) er[j*8 +: 8] = 8'(mx[i][j]);
      check(rxrow[i] == er, $sformatf("R3 R4 R9 R13 %s row %0d", tag, i), rxrow[i], er);
    end
  endtask

  function automatic void gen(logic [2:0] pat, int amp, int seed);
    int v;
    rs = {16'h5a5a, 16'(seed)} | 32'h1;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        v = int'(nxt() % (2 * amp + 1)) - amp;
        case (pat)
          3'd0: mc[i][j] = v;
          3'd1: mc[i][j] = (i == 0 && j == 0) ? v : 0;
          3'd2: mc[i][j] = ((i * 8 + j) == (seed % 63) + 1) ? v : 0;
          3'd3: mc[i][j] = (i == 0) ? v : 0;
          default: mc[i][j] = (j == 0) ? v : 0;
        endcase
        mp[i][j] = int'(nxt() % 256);
      end
  endfunction

  function automatic void clear_coefs();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) mc[i][j] = 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coef_valid = 1'b0; coef_put = 1'b0; coef_row = '0;
    pred_valid = 1'b0; pred_row = '0; pix_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(coef_ready == 1'b1 && pix_valid == 1'b0, "R1 during reset", {coef_ready, pix_valid}, 2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(coef_ready == 1'b1, "R1 coef_ready", coef_ready, 1);
    check(pix_valid == 1'b0, "R1 pix_valid", pix_valid, 0);
    check(pred_ready == 1'b0, "R1 pred_ready", pred_ready, 0);
    check(blk_done == 1'b0, "R1 blk_done", blk_done, 0);

    // table walk: R5 mid-grey, R6 residual, R8 column-0-only tiles
    for (int t = 0; t < 10; t++) begin
      gen(VEC[t][29:27], int'(VEC[t][26:16]), int'(VEC[t][15:0]));
      run_block(VEC[t][31], VEC[t][30], 0,
                (VEC[t][29:27] == 3'd4) ? "R8" : (VEC[t][31] ? "R5" : "R6"));
    end

    // R5: empty tile in mid-grey mode gives 128 everywhere
    clear_coefs();
    run_block(1'b1, 1'b0, 0, "R5 zero");
    check(rxrow[4][23:16] == 8'd128, "R5 mid-grey level", rxrow[4][23:16], 128);

    // R8: corner value 64 -> 45 after pass one -> 2 -> 130
    clear_coefs();
    mc[0][0] = 64;
    run_block(1'b1, 1'b1, 0, "R8 corner");
    check(rxrow[3][47:40] == 8'd130, "R8 single-term value", rxrow[3][47:40], 130);

    // R7: saturation at both ends
    clear_coefs();
    mc[0][0] = 32767;
    run_block(1'b1, 1'b0, 0, "R7 high");
    check(rxrow[0][7:0] == 8'd255, "R7 clamp high", rxrow[0][7:0], 255);
    mc[0][0] = -32768;
    run_block(1'b1, 1'b0, 0, "R7 low");
    check(rxrow[7][63:56] == 8'd0, "R7 clamp low", rxrow[7][63:56], 0);

    // R6 + R10: zero residual with late prediction returns the prediction
    gen(3'd0, 10, 77);
    clear_coefs();
    run_block(1'b0, 1'b1, 30, "R6 late pred");
    check(rxrow[5][15:8] == 8'(mp[5][1]), "R6 passthrough", rxrow[5][15:8], mp[5][1]);

    // R10: dense residual tile with late prediction and back-pressure
    gen(3'd0, 1200, 4242);
    run_block(1'b0, 1'b1, 40, "R10 dense late");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule